// File: doc/BRIEF.md
# Gated Pulse-Width Timer

This block measures how long an external, asynchronous signal stays at a chosen active level. It counts system clock cycles. The signal first passes through a synchronizer. An edge detector then finds the start of the active interval. An extended counter advances on every cycle in which the synchronized signal is active. The counter has a 16-bit low word and an 8-bit overflow tally. The true length in cycles is 65536 times the tally plus the low word.

Software-side control is a one-cycle `arm` strobe, which starts a fresh measurement, and a `clear` strobe, which returns the block to idle. In one-shot mode the block measures a single active interval. It then stops, holds its results and raises `done`. In accumulate mode it keeps adding every later active interval. The mode is captured when `arm` is pulsed. A synchronizer of fixed depth adds the same delay to both edges, so the measured width is not shifted. The remaining quantization is up to one clock period.

The block has no streaming data path. Every port is a plain control or status level.

Top module: `gated_width_timer`

## Requirements
- R1: After reset, `count`, `ovf_count`, `ovf_sat` and `done` are all 0.
- R2: With `gate_active_high`=1 and one-shot mode, a high pulse of N clock cycles on `gate_in` gives `count`=N and `done`=1. The result is present no later than 4 cycles after `gate_in` falls.
- R3: With `gate_active_high`=0, the low time of `gate_in` is measured in the same way as the high time in R2.
- R4: In one-shot mode, once `done` is 1 it stays 1 and `count`/`ovf_count` stay unchanged until the next `arm` or `clear`. Later gate pulses have no effect.
- R5: `arm` zeroes `count`, `ovf_count`, `ovf_sat` and `done`. Counting begins only at the first inactive-to-active transition after `arm`, so an interval that is already active when `arm` is pulsed is not counted.
- R6: `clear` zeroes all outputs and returns the block to idle. No gate activity is counted until the next `arm`.
- R7: Each time the 16-bit `count` passes from 65535 to 0, `ovf_count` increments. The measured length equals 65536*`ovf_count` + `count`.
- R8: `ovf_count` saturates at its all-ones value. A further wrap of `count` then sets `ovf_sat`, which stays set until `arm` or `clear`. `count` keeps wrapping.
- R9: If `one_shot_en`=0 at `arm`, the counts of all later active intervals are summed. `done` rises after the first interval ends and stays 1 while counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all counting is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_in | input | 1 | Asynchronous signal whose active time is measured |
| gate_active_high | input | 1 | 1: high level is active; 0: low level is active |
| one_shot_en | input | 1 | Mode sampled at `arm`: 1 one-shot, 0 accumulate |
| arm | input | 1 | One-cycle strobe: zero results and wait for an active edge |
| clear | input | 1 | One-cycle strobe: zero results and go idle (wins over `arm`) |
| count | output | 16 | Low word of the measured cycle count |
| ovf_count | output | 8 | Number of low-word wraps |
| ovf_sat | output | 1 | Sticky flag: a wrap occurred while the tally was full |
| done | output | 1 | An active interval has ended since `arm` |

## Verification
The assertions assume that `arm` and `clear` are single-cycle strobes driven from reset onward. They also assume that `gate_active_high` changes only while the block is idle or before an `arm`, because a change of polarity alone looks like a gate edge. The stimulus changes every input half a cycle away from the rising edge. It holds each gate level for at least one full cycle and changes polarity only after a settling gap that precedes a fresh `arm`. Under those conditions, the properties on one-step counting, frozen results and sticky saturation must hold for every pulse in the width sweeps.

// File: rtl/gwt_pkg.sv
package gwt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_COUNT = 2'd2,
    ST_HOLD  = 2'd3
  } gwt_state_e;
endpackage

// File: rtl/gwt_sync.sv
module gwt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gwt_gate_edge.sv
module gwt_gate_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  input  logic active_high,
  output logic act,
  output logic act_rise
);
  logic gate_s;
  logic act_q;

  gwt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (gate_in),
    .q_sync  (gate_s)
  );

  // active level after polarity selection
  assign act = active_high ? gate_s : ~gate_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;

  assign act_rise = act & ~act_q;
endmodule

// File: rtl/gwt_ext_counter.sv
module gwt_ext_counter #(
  parameter int CNT_W = 16,
  parameter int OVF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic [OVF_W-1:0] ovf,
  output logic             sat
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= '0;
      sat   <= 1'b0;
    end else if (zero) begin
      count <= '0;
      ovf   <= '0;
      sat   <= 1'b0;
    end else if (inc) begin
      count <= count + 1'b1;
      if (count == CNT_MAX) begin
        if (ovf == OVF_MAX) sat <= 1'b1;
        else                ovf <= ovf + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gated_width_timer.sv
module gated_width_timer
  import gwt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int OVF_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_in,
  input  logic             gate_active_high,
  input  logic             one_shot_en,
  input  logic             arm,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic [OVF_W-1:0] ovf_count,
  output logic             ovf_sat,
  output logic             done
);
  gwt_state_e state;
  logic       mode_q;
  logic       act;
  logic       act_rise;
  logic       inc;
  logic       zero;

  gwt_gate_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_in     (gate_in),
    .active_high (gate_active_high),
    .act         (act),
    .act_rise    (act_rise)
  );

  assign zero = clear | arm;
  assign inc  = ~zero & (((state == ST_WAIT) & act_rise) |
                         ((state == ST_COUNT) & act));

  gwt_ext_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .zero  (zero),
    .inc   (inc),
    .count (count),
    .ovf   (ovf_count),
    .sat   (ovf_sat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= 1'b1;
      done   <= 1'b0;
    end else if (clear) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else if (arm) begin
      state  <= ST_WAIT;
      mode_q <= one_shot_en;
      done   <= 1'b0;
    end else begin
      unique case (state)
        ST_WAIT:  if (act_rise) state <= ST_COUNT;
        ST_COUNT: if (!act) begin
                    done  <= 1'b1;
                    state <= mode_q ? ST_HOLD : ST_WAIT;
                  end
        default:  state <= state;
      endcase
    end
  end
endmodule

// File: rtl/gwt_checks.sv
module gwt_checks #(
  parameter int CNT_W = 16,
  parameter int OVF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             clear,
  input logic             mode_q,
  input logic [CNT_W-1:0] count,
  input logic [OVF_W-1:0] ovf_count,
  input logic             ovf_sat,
  input logic             done
);
  p_arm_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !clear) |=> (count == '0 && ovf_count == '0 && !ovf_sat && !done));

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0 && ovf_count == '0 && !done));

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q && !arm && !clear) |=> (done && $stable(count) && $stable(ovf_count)));

  p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !clear) |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

  p_tally_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !clear) |=> (ovf_count == $past(ovf_count) ||
                          ovf_count == OVF_W'($past(ovf_count) + 1'b1)));

  p_sat_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sat && !arm && !clear) |=> ovf_sat);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm && !clear) |=> done);
endmodule

bind gated_width_timer gwt_checks #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_gwt_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm       (arm),
  .clear     (clear),
  .mode_q    (mode_q),
  .count     (count),
  .ovf_count (ovf_count),
  .ovf_sat   (ovf_sat),
  .done      (done)
);

// File: tb/test_gated_width_timer.sv
module test_gated_width_timer;
  localparam int SW  = 4;
  localparam int SOW = 2;
  localparam int SMOD = 2 ** SW;
  localparam int SOMAX = 2 ** SOW - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_in = 1'b0;
  logic gate_active_high = 1'b1;
  logic one_shot_en = 1'b1;
  logic arm = 1'b0;
  logic clear = 1'b0;

  logic [15:0]    count;
  logic [7:0]     ovf_count;
  logic           ovf_sat, done;
  logic [SW-1:0]  s_count;
  logic [SOW-1:0] s_ovf;
  logic           s_sat, s_done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gated_width_timer i_gated_width_timer (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .gate_active_high(gate_active_high),
    .one_shot_en(one_shot_en), .arm(arm), .clear(clear),
    .count(count), .ovf_count(ovf_count), .ovf_sat(ovf_sat), .done(done)
  );

  gated_width_timer #(.CNT_W(SW), .OVF_W(SOW)) i_small (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .gate_active_high(gate_active_high),
    .one_shot_en(one_shot_en), .arm(arm), .clear(clear),
    .count(s_count), .ovf_count(s_ovf), .ovf_sat(s_sat), .done(s_done)
  );

  task automatic chk(input string tag, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm(input logic mode);
    one_shot_en = mode;
    arm = 1'b1;
    tick(1);
    arm = 1'b0;
    tick(2);
  endtask

  task automatic pulse(input int w);
    gate_in = gate_active_high;
    tick(w);
    gate_in = ~gate_active_high;
    tick(4);
  endtask

  task automatic set_pol(input logic p);
    gate_active_high = p;
    gate_in = ~p;
    tick(5);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 count", count, 0);
    chk("R1 ovf", ovf_count, 0);
    chk("R1 sat", ovf_sat, 0);
    chk("R1 done", done, 0);

    // R2 (active high) and R3 (active low): width sweep on both configurations
    for (int p = 1; p >= 0; p--) begin
      set_pol(p[0]);
      for (int w = 1; w <= 100; w++) begin
        do_arm(1'b1);
        pulse(w);
        chk(p ? "R2 count" : "R3 count", count, w);
        chk(p ? "R2 done" : "R3 done", done, 1);
        chk("R7 small count", s_count, w % SMOD);
        chk("R8 small ovf", s_ovf, (w / SMOD > SOMAX) ? SOMAX : w / SMOD);
        chk("R8 small sat", s_sat, (w / SMOD > SOMAX) ? 1 : 0);
        pulse(3);
        chk("R4 frozen count", count, w);
        chk("R4 done held", done, 1);
      end
    end

    // R5: interval already active at arm is ignored
    set_pol(1'b1);
    gate_in = 1'b1;
    tick(5);
    do_arm(1'b1);
    tick(5);
    gate_in = 1'b0;
    tick(5);
    chk("R5 preactive count", count, 0);
    chk("R5 preactive done", done, 0);
    pulse(6);
    chk("R5 next edge count", count, 6);

    // R6: clear zeroes and stops counting
    clear = 1'b1;
    tick(1);
    clear = 1'b0;
    chk("R6 count", count, 0);
    chk("R6 done", done, 0);
    pulse(9);
    chk("R6 idle count", count, 0);
    chk("R6 idle done", done, 0);

    // R9: accumulate mode sums intervals
    do_arm(1'b0);
    pulse(3);
    chk("R9 first done", done, 1);
    pulse(5);
    pulse(7);
    chk("R9 sum", count, 15);
    chk("R9 done", done, 1);
    chk("R9 small sum", s_count, 15);

    // R7/R8: long pulse across a 16-bit wrap
    do_arm(1'b1);
    pulse(65541);
    chk("R7 count", count, 5);
    chk("R7 ovf", ovf_count, 1);
    chk("R7 sat", ovf_sat, 0);
    chk("R8 small ovf", s_ovf, SOMAX);
    chk("R8 small sat", s_sat, 1);
    chk("R8 small count", s_count, 65541 % SMOD);

    finish_run();
  end
endmodule